// File: doc/BRIEF.md
# Serial LCD Command Frame Receiver

This block takes display data and control commands from a host over a three-line synchronous link. The lines are a serial data bit, a shift strobe and a load strobe, and all three arrive already synchronised to the system clock. Each rising edge of the shift strobe moves one bit into an 88-bit frame register. A complete frame holds 80 segment bits and then an 8-bit command byte. Only the most recent 88 bits are kept, so any extra bits sent at the head of a frame fall out.

On the rising edge of the load strobe the command byte is captured and decoded. The command can do one of three things:
- set a 2-bit refresh-rate code;
- turn the display on or off;
- write the 80 segment bits into one of four row latches. This happens only when the address carried in the command matches the strapped address of this chip.

For a row write, the latch follows the frame register for as long as the load strobe stays high. It freezes when the strobe falls. While the display is off, the row outputs read as all zeros, but the latch contents are kept.

The controller has three states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Waiting for a load. |
| `ST_PASS` | Load high; the addressed row follows the frame register. |
| `ST_HOLD` | Load high; the command was not a matching row write. |

It has four transitions:

| Transition | Condition |
|---|---|
| `ST_IDLE` to `ST_PASS` | Load rises with a matching row write. |
| `ST_IDLE` to `ST_HOLD` | Load rises with any other command. |
| `ST_PASS` to `ST_IDLE` | Load falls. |
| `ST_HOLD` to `ST_IDLE` | Load falls. |

Top module: `lcd_frame_rx`

## Requirements
- R1: After synchronous active-low reset, every row latch is zero, `disp_on` is 0 and `rate_code` is 00.
- R2: One bit is shifted in per rising edge of `ser_clk`. Only the last 88 bits shifted count, so extra leading bits are discarded.
- R3: The frame is sent as data bits D1..D80 and then command bits C0..C7, with C7 sent last. D1 drives SEG80, which is bit 79 of the row's 80-bit slice. D80 drives SEG1, which is bit 0.
- R4: A command whose C7:C6 = 00 changes neither `rate_code`, `disp_on` nor any row latch.
- R5: A command whose C7:C6 = 01 loads `rate_code` with {C5,C4}.
- R6: A command whose C7:C6 = 10 sets `disp_on` to C4 when C5 = 1. When C5 = 0 the command has no effect.
- R7: A command whose C7:C6 = 11 and whose {C5,C4,C3,C2} equals `chip_addr` writes the 80 data bits into row {C1,C0}. Row r appears at `seg_rows[r*80 +: 80]`.
- R8: A row write whose address bits differ from `chip_addr` leaves every row latch unchanged.
- R9: A refresh-rate or display command works when only C4..C7 were shifted since the previous frame.
- R10: The command is taken from the frame register at the rise of `ser_load`. While the load is high, the addressed row follows further shifting. After the load falls, the row no longer changes.
- R11: While `disp_on` is 0, `seg_rows` is all zeros. Turning the display back on restores the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Shift strobe; sampled on its rising edge |
| ser_load | input | 1 | Load strobe; rise executes the command, fall freezes the row |
| chip_addr | input | 4 | Strapped chip address {SA1,SA0,A1,A0} |
| seg_rows | output | 320 | Four 80-bit rows, forced to zero while the display is off |
| disp_on | output | 1 | Display-enable flag |
| rate_code | output | 2 | Refresh-rate code |

## Verification
The embedded assertions are checked on every clock cycle. They cover the following:
- Each shift strobe places the sampled data bit at the bottom of the frame register, and the register never moves without a strobe.
- `rate_code` and `disp_on` change only at a load rise, and never for a command with C7:C6 = 00.
- A row write begins only immediately after a load rise, and an address mismatch never enables a write.
- No latch changes while the write enable is low.

Only the directed scenarios can show the rest:
- The bit-to-segment mapping, the decoding of the row index, and the discarding of leading bits.
- Short command frames.
- The pass-through-then-freeze behaviour across a load pulse.
- Blanking of the rows and their restoration when the display is turned back on.

// File: rtl/lcdrx_pkg.sv
package lcdrx_pkg;
    localparam int SEG_N     = 80;
    localparam int CMD_W     = 8;
    localparam int ROW_N     = 4;
    localparam int ADDR_W    = 4;
    localparam int RATE_W    = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_RATE  = 2'b01,
        OP_DISP  = 2'b10,
        OP_WRITE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PASS = 2'b01,
        ST_HOLD = 2'b10
    } st_e;
endpackage

// File: rtl/lcdrx_edge.sv
module lcdrx_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/lcdrx_shifter.sv
module lcdrx_shifter #(
    parameter int FRAME_W = 88
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] sr
);
    always_ff @(posedge clk) begin
        if (!rst_n)        sr <= '0;
        else if (shift_en) sr <= {sr[FRAME_W-2:0], din};
    end

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sr[0] == $past(din));

    // R2
    shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr));
endmodule

// File: rtl/lcdrx_ctrl.sv
module lcdrx_ctrl
    import lcdrx_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int ROW_N  = 4,
    parameter int ADDR_W = 4,
    parameter int RATE_W = 2,
    localparam int SEL_W = $clog2(ROW_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_rise,
    input  logic              load_fall,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [ADDR_W-1:0] chip_addr,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_row,
    output logic              disp_on,
    output logic [RATE_W-1:0] rate_code
);
    localparam int OP_HI   = CMD_W - 1;
    localparam int OP_LO   = CMD_W - 2;
    localparam int ARG_HI  = CMD_W - 3;
    localparam int ARG_LO  = CMD_W - 4;

    st_e                state, state_nx;
    op_e                op;
    logic               addr_hit;
    logic [SEL_W-1:0]   row_q;

    assign op       = op_e'(cmd[OP_HI:OP_LO]);
    assign addr_hit = (cmd[ARG_HI -: ADDR_W] == chip_addr);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (load_rise)
                         state_nx = (op == OP_WRITE && addr_hit) ? ST_PASS : ST_HOLD;
            ST_PASS: if (load_fall) state_nx = ST_IDLE;
            ST_HOLD: if (load_fall) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_code <= '0;
            disp_on   <= 1'b0;
            row_q     <= '0;
        end else if (state == ST_IDLE && load_rise) begin
            unique case (op)
                OP_RATE:  rate_code <= cmd[ARG_HI:ARG_LO];
                OP_DISP:  if (cmd[ARG_HI]) disp_on <= cmd[ARG_LO];
                OP_WRITE: row_q <= cmd[SEL_W-1:0];
                default:  ;
            endcase
        end
    end

    assign wr_en  = (state == ST_PASS);
    assign wr_row = row_q;

    // R4
    nop_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_rise && cmd[OP_HI:OP_LO] == 2'b00) |=> ($stable(rate_code) && $stable(disp_on)));

    // R5
    rate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_rise |=> ($stable(rate_code) && $stable(disp_on)));

    // R8
    addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_rise && cmd[OP_HI:OP_LO] == 2'b11 && cmd[ARG_HI -: ADDR_W] != chip_addr) |=> !wr_en);

    // R10
    pass_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(load_rise));
endmodule

// File: rtl/lcdrx_rows.sv
module lcdrx_rows #(
    parameter int SEG_N = 80,
    parameter int ROW_N = 4,
    localparam int SEL_W = $clog2(ROW_N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_row,
    input  logic [SEG_N-1:0]       wdata,
    output logic [ROW_N*SEG_N-1:0] rows_flat
);
    for (genvar r = 0; r < ROW_N; r++) begin : g_row
        logic [SEG_N-1:0] mem_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q <= '0;
            else if (wr_en && wr_row == SEL_W'(r))
                mem_q <= wdata;
        end
        assign rows_flat[r*SEG_N +: SEG_N] = mem_q;
    end

    // R10
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rows_flat));
endmodule

// File: rtl/lcd_frame_rx.sv
module lcd_frame_rx
    import lcdrx_pkg::*;
#(
    parameter int SEGS   = SEG_N,
    parameter int CMDW   = CMD_W,
    parameter int ROWS   = ROW_N,
    parameter int ADDRW  = ADDR_W,
    parameter int RATEW  = RATE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_data,
    input  logic                 ser_clk,
    input  logic                 ser_load,
    input  logic [ADDRW-1:0]     chip_addr,
    output logic [ROWS*SEGS-1:0] seg_rows,
    output logic                 disp_on,
    output logic [RATEW-1:0]     rate_code
);
    localparam int FRAME_W = SEGS + CMDW;
    localparam int SEL_W   = $clog2(ROWS);

    logic [1:0]            rise, fall;
    logic [FRAME_W-1:0]    sr;
    logic [CMDW-1:0]       cmd;
    logic [SEGS-1:0]       wdata;
    logic                  wr_en;
    logic [SEL_W-1:0]      wr_row;
    logic [ROWS*SEGS-1:0]  rows_flat;

    lcdrx_edge #(.W(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({ser_load, ser_clk}),
        .rise (rise),
        .fall (fall)
    );

    lcdrx_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(rise[0]),
        .din     (ser_data),
        .sr      (sr)
    );

    // Last bit shifted is the top command bit, so the command byte is bit-reversed.
    for (genvar i = 0; i < CMDW; i++) begin : g_cmd
        assign cmd[i] = sr[CMDW-1-i];
    end

    // The earliest data bit sits highest and maps to the top segment.
    assign wdata = sr[FRAME_W-1:CMDW];

    lcdrx_ctrl #(
        .CMD_W (CMDW),
        .ROW_N (ROWS),
        .ADDR_W(ADDRW),
        .RATE_W(RATEW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_rise(rise[1]),
        .load_fall(fall[1]),
        .cmd      (cmd),
        .chip_addr(chip_addr),
        .wr_en    (wr_en),
        .wr_row   (wr_row),
        .disp_on  (disp_on),
        .rate_code(rate_code)
    );

    lcdrx_rows #(.SEG_N(SEGS), .ROW_N(ROWS)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_row   (wr_row),
        .wdata    (wdata),
        .rows_flat(rows_flat)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_blank
        assign seg_rows[r*SEGS +: SEGS] = disp_on ? rows_flat[r*SEGS +: SEGS] : '0;
    end
endmodule

// File: tb/lcd_frame_rx_bench.sv
module lcd_frame_rx_bench;
    localparam int SEGS = 80;
    localparam int ROWS = 4;
    localparam logic [3:0] MY_ADDR = 4'b1010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_load = 1'b0;
    logic [3:0] chip_addr = MY_ADDR;
    logic [ROWS*SEGS-1:0] seg_rows;
    logic disp_on;
    logic [1:0] rate_code;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [SEGS-1:0] shadow [ROWS];

    always #10 clk = ~clk;

    lcd_frame_rx u_lcd_frame_rx (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_load(ser_load), .chip_addr(chip_addr), .seg_rows(seg_rows),
        .disp_on(disp_on), .rate_code(rate_code)
    );

    task automatic chk(input bit ok, input string req, input logic [319:0] act, input logic [319:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) ser_data = b;
        @(negedge clk) ser_clk = 1'b1;
        @(negedge clk);
        @(negedge clk) ser_clk = 1'b0;
        @(negedge clk);
    endtask

    // D1 (drives seg[79]) first, D80 (seg[0]) last, then C0..C7
    task automatic send_frame(input logic [SEGS-1:0] seg, input logic [7:0] cmd);
        for (int k = SEGS - 1; k >= 0; k--) send_bit(seg[k]);
        for (int c = 0; c < 8; c++) send_bit(cmd[c]);
    endtask

    task automatic load_hi();
        @(negedge clk) ser_load = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic load_lo();
        @(negedge clk) ser_load = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [319:0] all_rows();
        return {shadow[3], shadow[2], shadow[1], shadow[0]};
    endfunction

    task automatic t_reset();
        chk(seg_rows == '0, "R1 rows", seg_rows, '0);
        chk(disp_on == 1'b0, "R1 disp", 320'(disp_on), 0);
        chk(rate_code == 2'b00, "R1 rate", 320'(rate_code), 0);
    endtask

    task automatic t_disp_on();
        send_frame('0, 8'b1011_0000);
        load_hi(); load_lo();
        chk(disp_on == 1'b1, "R6 display on", 320'(disp_on), 1);
        chk(seg_rows == '0, "R1 rows zero after reset", seg_rows, '0);
    endtask

    task automatic t_mapping();
        logic [SEGS-1:0] p;
        p = '0; p[79] = 1'b1;
        send_frame(p, {2'b11, MY_ADDR, 2'b00});
        load_hi(); load_lo();
        shadow[0] = p;
        chk(seg_rows[79] == 1'b1 && seg_rows[SEGS-1:0] == p, "R3 first bit to SEG80",
            320'(seg_rows[SEGS-1:0]), 320'(p));
        p = '0; p[0] = 1'b1;
        send_frame(p, {2'b11, MY_ADDR, 2'b00});
        load_hi(); load_lo();
        shadow[0] = p;
        chk(seg_rows[SEGS-1:0] == p, "R3 last bit to SEG1", 320'(seg_rows[SEGS-1:0]), 320'(p));
    endtask

    task automatic t_rows();
        for (int r = 0; r < ROWS; r++) begin
            logic [SEGS-1:0] p;
            p = {20{4'(r + 4'h5)}} ^ (80'h1 << (r * 7));
            // R2: junk leading bits precede the frame and must be discarded
            for (int j = 0; j < 5; j++) send_bit(1'b1);
            send_frame(p, {2'b11, MY_ADDR, 2'(r)});
            load_hi(); load_lo();
            shadow[r] = p;
            chk(seg_rows == all_rows(), "R7 R2 row write", seg_rows, all_rows());
        end
    endtask

    task automatic t_mismatch();
        send_frame({SEGS{1'b1}}, {2'b11, 4'b0101, 2'b01});
        load_hi(); load_lo();
        chk(seg_rows == all_rows(), "R8 address mismatch", seg_rows, all_rows());
    endtask

    task automatic t_rate();
        send_frame({SEGS{1'b1}}, 8'b0110_0000);
        load_hi(); load_lo();
        chk(rate_code == 2'b10, "R5 rate", 320'(rate_code), 2);
        chk(disp_on == 1'b1, "R5 disp untouched", 320'(disp_on), 1);
    endtask

    task automatic t_ignore();
        send_frame({SEGS{1'b1}}, 8'b0011_1111);
        load_hi(); load_lo();
        chk(rate_code == 2'b10 && disp_on == 1'b1, "R4 no-op flags",
            320'({disp_on, rate_code}), 320'(3'b110));
        chk(seg_rows == all_rows(), "R4 no-op rows", seg_rows, all_rows());
        send_frame('0, 8'b1000_0000);
        load_hi(); load_lo();
        chk(disp_on == 1'b1, "R6 C5 clear ignored", 320'(disp_on), 1);
    endtask

    task automatic t_short();
        // C4..C7 = 1,1,1,0 : rate 11
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        load_hi(); load_lo();
        chk(rate_code == 2'b11, "R9 short rate", 320'(rate_code), 3);
        // C4..C7 = 0,1,0,1 : display off
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        load_hi(); load_lo();
        chk(disp_on == 1'b0, "R9 short display off", 320'(disp_on), 0);
        chk(seg_rows == '0, "R11 blanked", seg_rows, '0);
        // C4..C7 = 1,1,0,1 : display on
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        load_hi(); load_lo();
        chk(seg_rows == all_rows(), "R11 restored", seg_rows, all_rows());
    endtask

    task automatic t_pass();
        logic [SEGS-1:0] p;
        logic [7:0] c;
        p = 80'hC3A5_0F1E_7788_99AB_CDEF;
        c = {2'b11, MY_ADDR, 2'b10};
        send_frame(p, c);
        load_hi();
        shadow[2] = p;
        chk(seg_rows == all_rows(), "R10 load high writes", seg_rows, all_rows());
        send_bit(1'b1);
        shadow[2] = {p[SEGS-2:0], c[0]};
        chk(seg_rows == all_rows(), "R10 pass-through while high", seg_rows, all_rows());
        load_lo();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        chk(seg_rows == all_rows(), "R10 frozen after fall", seg_rows, all_rows());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < ROWS; r++) shadow[r] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_disp_on();
        t_mapping();
        t_rows();
        t_mismatch();
        t_rate();
        t_ignore();
        t_short();
        t_pass();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule